// File: doc/BRIEF.md
# Partitioned Memory Access Checker

This block decides whether each operation on a 512-byte store may proceed. The store is split into four 128-byte arrays. Each array has a 4-bit control nibble. Two bits of the nibble say which password an operation needs. The other two bits say which operations the array permits at all. One of those function modes is program-only: a write may clear bits but never set them.

The block sees every operation request, the configuration-mode flag and the password-verified flag. From these it produces three outputs, all one clock later:
- a registered password-requirement code,
- an allow or deny strobe,
- a standby request when the array's function limits refuse the access.

A write request opens a write session. Every data byte in that session then gets its own decision, made from the stored and incoming byte values. Accepted bytes are collected in an 8-byte sector buffer. The buffer is tagged with the sector number and fills in wrap-around order.

The surrounding serial engine, password comparison and nonvolatile timing live elsewhere. They use the strobes to acknowledge the transfer or to drop to standby.

Top module: `bank_access_guard`

## Requirements
- R1: The array is chosen by `req_addr[8:7]` (0 to 3). `ctl_a[3:0]` is the nibble of array 0, `ctl_a[7:4]` of array 1, `ctl_b[3:0]` of array 2 and `ctl_b[7:4]` of array 3. Within a nibble, bit 3 is the write-password flag X, bit 2 is the read-password flag Y, and bits 1:0 are the function code {Z,T}.
- R2: One clock after `req_vld`, `pw_code` equals {X,Y} of the addressed array. It holds that value until the next request.
- R3: A read request is answered one clock later. It gets `grant` when {Z,T} is not 11 and either Y is 0 or `pw_ok` is 1. Otherwise it gets `deny`.
- R4: A write request is refused with `deny` one clock later in two cases: {Z,T} is 10 or 11, or X is 1 while `pw_ok` is 0. Otherwise it raises no strobe and opens a write session. Any request closes an earlier session.
- R5: Each `wr_vld` byte in an open session gets `grant` one clock later. The exception is function code 01: if any bit is 0 in `wr_old` and 1 in `wr_new`, the byte gets `deny` and the session closes.
- R6: `standby_req` pulses together with `deny` when the refusal comes from the function code (R3, R4) or from a bit being set (R5). A refusal only for a missing password gives `deny` without `standby_req`.
- R7: While `cfg_mode` is 1 at request time, every password and function limit is bypassed, for the request and for every byte of the session it opens.
- R8: An opened session loads `sec_tag` with `req_addr[8:3]` and a byte slot pointer with `req_addr[2:0]`. Each accepted byte is written to `sec_data[8*p+7:8*p]` at slot p, and p then advances modulo 8, so a ninth byte overwrites an earlier one.
- R9: A `wr_vld` byte outside an open session, or a rejected byte, leaves `sec_data` unchanged. A byte outside a session also raises no strobe.
- R10: After a synchronous reset (`rst_n` low at a clock edge), all strobes, `pw_code`, `sec_tag` and `sec_data` are zero and no session is open.
- R11: `grant` and `deny` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Operation request strobe |
| req_wr | input | 1 | 1 = sector write, 0 = read |
| req_addr | input | 9 | Byte address of the request |
| cfg_mode | input | 1 | Configuration password accepted; overrides limits |
| pw_ok | input | 1 | Read or write password accepted |
| ctl_a | input | 8 | Control nibbles of arrays 1 and 0 |
| ctl_b | input | 8 | Control nibbles of arrays 3 and 2 |
| wr_vld | input | 1 | Data byte strobe |
| wr_old | input | 8 | Currently stored byte at the target |
| wr_new | input | 8 | Incoming byte |
| pw_code | output | 2 | {X,Y} of the last addressed array |
| grant | output | 1 | Operation or byte allowed |
| deny | output | 1 | Operation or byte refused |
| standby_req | output | 1 | Refusal by function limit; drop to standby |
| sec_tag | output | 6 | Sector number of the open or last session |
| sec_data | output | 64 | Sector buffer, slot p in bits 8p+7:8p |

## Verification
The assertions assume two things about the inputs. First, `req_vld` and `wr_vld` never rise in the same cycle; if they do, the request wins and the byte is dropped. Second, the control bytes and `cfg_mode` are steady while a decision is pending. The stimulus keeps to this by driving at most one strobe per cycle, changing the control bytes only between operations, and returning every strobe low for the next cycle.

// File: rtl/pmac_pkg.sv
// Shared types for the partitioned memory access checker.
// Assumes 8-bit data bytes and a 4-bit control nibble per array.
package pmac_pkg;
    parameter int BYTE_W = 8;

    // Function code {Z,T}
    typedef enum logic [1:0] {
        FN_FREE   = 2'b00,
        FN_PROG   = 2'b01,
        FN_RDONLY = 2'b10,
        FN_LOCKED = 2'b11
    } fn_mode_e;

    // One control nibble: bit3 write pw, bit2 read pw, bits1:0 function
    typedef struct packed {
        logic     pw_wr;
        logic     pw_rd;
        fn_mode_e fn;
    } acl_t;

    // True when the new byte sets any bit that is clear in the old byte
    function automatic logic raises_bit(input logic [BYTE_W-1:0] old_b,
                                        input logic [BYTE_W-1:0] new_b);
        return |(~old_b & new_b);
    endfunction
endpackage

// File: rtl/pmac_acl_sel.sv
// Picks the control nibble of the addressed array out of the packed
// control vector. Assumes nibble i belongs to array i.
module pmac_acl_sel
    import pmac_pkg::*;
#(
    parameter  int N_ARR = 4,
    localparam int SEL_W = $clog2(N_ARR)
) (
    input  logic [4*N_ARR-1:0] acl_vec,
    input  logic [SEL_W-1:0]   sel,
    output acl_t               acl
);
    logic [3:0] nib [N_ARR];

    // Split the control vector into per-array nibbles
    for (genvar i = 0; i < N_ARR; i++) begin : g_nib
        assign nib[i] = acl_vec[4*i +: 4];
    end

    assign acl = acl_t'(nib[sel]);
endmodule

// File: rtl/pmac_rule.sv
// Combinational request rule: finds a missing password and a function
// limit for the request. Configuration mode clears both.
module pmac_rule
    import pmac_pkg::*;
(
    input  acl_t acl,
    input  logic is_wr,
    input  logic cfg_mode,
    input  logic pw_ok,
    output logic pw_short,
    output logic fn_block
);
    // Decode password need and function limit for the requested operation
    always_comb begin
        pw_short = 1'b0;
        fn_block = 1'b0;
        if (!cfg_mode) begin
            pw_short = (is_wr ? acl.pw_wr : acl.pw_rd) && !pw_ok;
            if (is_wr) fn_block = (acl.fn == FN_RDONLY) || (acl.fn == FN_LOCKED);
            else       fn_block = (acl.fn == FN_LOCKED);
        end
    end
endmodule

// File: rtl/pmac_sector_buf.sv
// Eight-slot sector buffer. An open loads the tag and the start slot;
// each store writes one byte and advances the slot with wrap-around.
// Assumes SEC_BYTES is a power of two.
module pmac_sector_buf
    import pmac_pkg::*;
#(
    parameter  int SEC_BYTES = 8,
    parameter  int TAG_W     = 6,
    localparam int OFS_W     = $clog2(SEC_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        open,
    input  logic [TAG_W-1:0]            open_tag,
    input  logic [OFS_W-1:0]            open_ofs,
    input  logic                        store,
    input  logic [BYTE_W-1:0]           store_byte,
    output logic [TAG_W-1:0]            tag,
    output logic [SEC_BYTES*BYTE_W-1:0] data
);
    logic [TAG_W-1:0]  tag_q;
    logic [OFS_W-1:0]  ptr_q;
    logic [BYTE_W-1:0] mem_q [SEC_BYTES];

    // Tag, slot pointer and byte storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            ptr_q <= '0;
            for (int i = 0; i < SEC_BYTES; i++) mem_q[i] <= '0;
        end else if (open) begin
            tag_q <= open_tag;
            ptr_q <= open_ofs;
        end else if (store) begin
            mem_q[ptr_q] <= store_byte;
            ptr_q        <= ptr_q + 1'b1;
        end
    end

    // Flatten the slots onto the output bus
    for (genvar i = 0; i < SEC_BYTES; i++) begin : g_flat
        assign data[i*BYTE_W +: BYTE_W] = mem_q[i];
    end
    assign tag = tag_q;

    // R8
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(tag_q));

    // R8
    store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !open) |=> (mem_q[$past(ptr_q)] == $past(store_byte)));
endmodule

// File: rtl/bank_access_guard.sv
// Access checker for a store split into equal arrays. Registers a
// grant/deny decision one clock after each request or session byte,
// tracks the open write session and collects accepted bytes.
// Assumes req_vld and wr_vld are not high together (request wins).
module bank_access_guard
    import pmac_pkg::*;
#(
    parameter  int N_ARR     = 4,
    parameter  int ARR_BYTES = 128,
    parameter  int SEC_BYTES = 8,
    localparam int ADDR_W    = $clog2(N_ARR * ARR_BYTES),
    localparam int SEL_W     = $clog2(N_ARR),
    localparam int OFS_W     = $clog2(SEC_BYTES),
    localparam int TAG_W     = ADDR_W - OFS_W,
    localparam int CTL_W     = 2 * BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_vld,
    input  logic                        req_wr,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic                        cfg_mode,
    input  logic                        pw_ok,
    input  logic [BYTE_W-1:0]           ctl_a,
    input  logic [BYTE_W-1:0]           ctl_b,
    input  logic                        wr_vld,
    input  logic [BYTE_W-1:0]           wr_old,
    input  logic [BYTE_W-1:0]           wr_new,
    output logic [1:0]                  pw_code,
    output logic                        grant,
    output logic                        deny,
    output logic                        standby_req,
    output logic [TAG_W-1:0]            sec_tag,
    output logic [SEC_BYTES*BYTE_W-1:0] sec_data
);
    logic [CTL_W-1:0] acl_vec;
    acl_t             req_acl;
    logic             pw_short, fn_block, refuse;
    logic             byte_bad, sess_open, sess_store;

    logic             grant_q, deny_q, standby_q;
    logic [1:0]       pw_code_q;
    logic             sess_q, sess_cfg_q;
    fn_mode_e         sess_fn_q;

    assign acl_vec = {ctl_b, ctl_a};

    pmac_acl_sel #(.N_ARR(N_ARR)) i_sel (
        .acl_vec (acl_vec),
        .sel     (req_addr[ADDR_W-1 -: SEL_W]),
        .acl     (req_acl)
    );

    pmac_rule i_rule (
        .acl      (req_acl),
        .is_wr    (req_wr),
        .cfg_mode (cfg_mode),
        .pw_ok    (pw_ok),
        .pw_short (pw_short),
        .fn_block (fn_block)
    );

    assign refuse = pw_short || fn_block;

    // Byte check against the mode captured when the session opened
    always_comb begin
        byte_bad = !sess_cfg_q && (sess_fn_q == FN_PROG) && raises_bit(wr_old, wr_new);
    end

    assign sess_open  = req_vld && req_wr && !refuse;
    assign sess_store = !req_vld && wr_vld && sess_q && !byte_bad;

    // Decision strobes, password code and write-session state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q    <= 1'b0;
            deny_q     <= 1'b0;
            standby_q  <= 1'b0;
            pw_code_q  <= 2'b00;
            sess_q     <= 1'b0;
            sess_cfg_q <= 1'b0;
            sess_fn_q  <= FN_FREE;
        end else begin
            grant_q   <= 1'b0;
            deny_q    <= 1'b0;
            standby_q <= 1'b0;
            if (req_vld) begin
                pw_code_q  <= {req_acl.pw_wr, req_acl.pw_rd};
                grant_q    <= !req_wr && !refuse;
                deny_q     <= refuse;
                standby_q  <= fn_block;
                sess_q     <= sess_open;
                sess_cfg_q <= cfg_mode;
                sess_fn_q  <= req_acl.fn;
            end else if (wr_vld && sess_q) begin
                grant_q   <= !byte_bad;
                deny_q    <= byte_bad;
                standby_q <= byte_bad;
                if (byte_bad) sess_q <= 1'b0;
            end
        end
    end

    pmac_sector_buf #(.SEC_BYTES(SEC_BYTES), .TAG_W(TAG_W)) i_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .open       (sess_open),
        .open_tag   (req_addr[ADDR_W-1:OFS_W]),
        .open_ofs   (req_addr[OFS_W-1:0]),
        .store      (sess_store),
        .store_byte (wr_new),
        .tag        (sec_tag),
        .data       (sec_data)
    );

    assign pw_code     = pw_code_q;
    assign grant       = grant_q;
    assign deny        = deny_q;
    assign standby_req = standby_q;

    // R11
    grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_q && deny_q));

    // R6
    standby_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_q |-> deny_q);

    // R3
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q || deny_q) |-> $past(req_vld || (wr_vld && sess_q)));

    // R7
    cfg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cfg_mode && !req_wr) |=> grant_q);

    // R7
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && cfg_mode && req_wr) |=> (!deny_q && sess_q));
endmodule

// File: tb/test_bank_access_guard.sv
module test_bank_access_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 0, req_wr = 0, cfg_mode = 0, pw_ok = 0, wr_vld = 0;
    logic [8:0]  req_addr = '0;
    logic [7:0]  ctl_a = '0, ctl_b = '0, wr_old = '0, wr_new = '0;
    logic [1:0]  pw_code;
    logic        grant, deny, standby_req;
    logic [5:0]  sec_tag;
    logic [63:0] sec_data;

    int n_vec = 0, n_bad = 0;

    // Reference model state
    logic       m_sess = 0, m_scfg = 0;
    logic [1:0] m_sfn = '0, m_pw = '0;
    logic [5:0] m_tag = '0;
    int         m_ptr = 0;
    logic [7:0] m_buf [8];
    logic       e_grant = 0, e_deny = 0, e_stby = 0;

    always #5 clk = ~clk;

    bank_access_guard i_bank_access_guard (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_addr(req_addr), .cfg_mode(cfg_mode), .pw_ok(pw_ok),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .wr_vld(wr_vld), .wr_old(wr_old),
        .wr_new(wr_new), .pw_code(pw_code), .grant(grant), .deny(deny),
        .standby_req(standby_req), .sec_tag(sec_tag), .sec_data(sec_data)
    );

    // R1: nibble layout of the two control bytes
    function automatic logic [3:0] nib_of(input logic [1:0] a);
        case (a)
            2'd0:    return ctl_a[3:0];
            2'd1:    return ctl_a[7:4];
            2'd2:    return ctl_b[3:0];
            default: return ctl_b[7:4];
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input int act, input int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step(input logic rv, input logic rw, input logic [8:0] ad,
                        input logic cf, input logic pk, input logic wv,
                        input logic [7:0] ob, input logic [7:0] nb, input string rq);
        logic [3:0] n;
        logic fnb, pws, bad;
        req_vld = rv; req_wr = rw; req_addr = ad; cfg_mode = cf; pw_ok = pk;
        wr_vld = wv; wr_old = ob; wr_new = nb;
        e_grant = 0; e_deny = 0; e_stby = 0;
        if (rv) begin
            n    = nib_of(ad[8:7]);
            m_pw = {n[3], n[2]};
            fnb  = !cf && (rw ? n[1] : (n[1] && n[0]));
            pws  = !cf && (rw ? n[3] : n[2]) && !pk;
            e_deny  = fnb || pws;
            e_stby  = fnb;
            e_grant = !rw && !e_deny;
            m_sess  = 0;
            if (rw && !e_deny) begin
                m_sess = 1; m_scfg = cf; m_sfn = n[1:0];
                m_tag = ad[8:3]; m_ptr = int'(ad[2:0]);
            end
        end else if (wv && m_sess) begin
            bad = !m_scfg && (m_sfn == 2'b01) && ((~ob & nb) != 8'h00);
            if (bad) begin
                e_deny = 1; e_stby = 1; m_sess = 0;
            end else begin
                e_grant = 1;
                m_buf[m_ptr] = nb;
                m_ptr = (m_ptr + 1) % 8;
            end
        end
        @(posedge clk);
        #1;
        n_vec++;
        chk(rq, "grant", int'(grant), int'(e_grant));
        chk(rq, "deny", int'(deny), int'(e_deny));
        chk(rq, "standby_req", int'(standby_req), int'(e_stby));
        chk(rq, "pw_code", int'(pw_code), int'(m_pw));
        chk(rq, "sec_tag", int'(sec_tag), int'(m_tag));
        for (int i = 0; i < 8; i++)
            chk(rq, $sformatf("sec_data byte %0d", i), int'(sec_data[8*i +: 8]), int'(m_buf[i]));
        if (grant && deny) chk("R11", "grant&deny", 1, 0);
        req_vld = 0; wr_vld = 0;
    endtask

    task automatic idle(input string rq);
        step(0, 0, 9'h0, 0, 0, 0, 8'h00, 8'h00, rq);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL R10: watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_buf[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        idle("R10");

        // Sweep every control code in every array; other arrays get the inverse code
        for (int a = 0; a < 4; a++) begin
            for (int c = 0; c < 16; c++) begin
                logic [3:0] cc, oc;
                logic [8:0] ad;
                cc = 4'(c); oc = ~cc;
                ctl_a = {oc, oc}; ctl_b = {oc, oc};
                case (a)
                    0: ctl_a[3:0] = cc;
                    1: ctl_a[7:4] = cc;
                    2: ctl_b[3:0] = cc;
                    default: ctl_b[7:4] = cc;
                endcase
                ad = {2'(a), 7'((c * 40 + a * 3) % 128)};
                step(1, 0, ad, 0, 0, 0, 8'h00, 8'h00, "R1 R2 R3 R6");
                step(1, 0, ad, 0, 1, 0, 8'h00, 8'h00, "R1 R3");
                step(1, 1, ad, 0, 0, 0, 8'h00, 8'h00, "R4 R6");
                step(0, 0, 9'h0, 0, 0, 1, 8'hFF, 8'h3C, "R5 R9");
                step(1, 1, ad, 0, 1, 0, 8'h00, 8'h00, "R4 R2");
                step(0, 0, 9'h0, 0, 0, 1, 8'hFF, 8'h0F, "R5 R8");
                step(0, 0, 9'h0, 0, 0, 1, 8'h0F, 8'hF0, "R5 R6 R9");
                step(0, 0, 9'h0, 0, 0, 1, 8'h00, 8'h00, "R5 R9");
                idle("R2");
            end
        end

        // Configuration mode bypasses every limit
        ctl_a = 8'hFF; ctl_b = 8'hFF;
        for (int a = 0; a < 4; a++) begin
            step(1, 0, {2'(a), 7'h11}, 1, 0, 0, 8'h00, 8'h00, "R7");
            step(1, 1, {2'(a), 7'h28}, 1, 0, 0, 8'h00, 8'h00, "R7");
            step(0, 0, 9'h0, 0, 0, 1, 8'h00, 8'hFF, "R7 R8");
        end
        ctl_a = 8'h55; ctl_b = 8'h55;
        step(1, 1, 9'h0C3, 1, 0, 0, 8'h00, 8'h00, "R7");
        step(0, 0, 9'h0, 0, 0, 1, 8'h00, 8'hA5, "R7 R5");

        // Sector fill with wrap-around
        ctl_a = 8'h00; ctl_b = 8'h00;
        step(1, 1, 9'h1E5, 0, 0, 0, 8'h00, 8'h00, "R4 R8");
        for (int i = 0; i < 10; i++)
            step(0, 0, 9'h0, 0, 0, 1, 8'hFF, 8'(8'h40 + i), "R8");
        step(1, 0, 9'h1E5, 0, 0, 0, 8'h00, 8'h00, "R3 R4");
        step(0, 0, 9'h0, 0, 0, 1, 8'hFF, 8'h99, "R9");
        idle("R9");

        // Reset mid-run returns everything to zero
        rst_n = 0;
        @(posedge clk); #1;
        rst_n = 1;
        m_sess = 0; m_pw = '0; m_tag = '0; m_ptr = 0;
        for (int i = 0; i < 8; i++) m_buf[i] = 8'h00;
        idle("R10");
        step(0, 0, 9'h0, 0, 0, 1, 8'h00, 8'h77, "R10 R9");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule